// File: doc/BRIEF.md
# Interrupt Request Front End

This block sits between two active-low interrupt request wires and a processor core. There is a fast line and a normal line. Each wire can be passed through a two-flop synchronizer. A run-time pin can instead bypass that synchronizer when the source is already in the core's clock domain. Each conditioned request is qualified by an enable bit that the core supplies. The two qualified requests are then arbitrated, and the fast line always wins over the normal one.

The block presents a registered take-interrupt strobe, a flag naming the winner and the address of the winner's exception vector. The vector table sits either at the bottom of memory or at 0xFFFF0000, as a second pin chooses. The core uses these outputs to start exception entry. Requests are levels: nothing is latched, so a request counts only while its wire is held low.

Top module: `irq_front_end`

## Requirements
- R1: While `rst_n` is low at a clock edge, `take_irq` is 0, `sel_fast` is 0 and `vec_addr` is 0, whatever the request inputs are. The synchronizer flops reset to the inactive high level.
- R2: With `sync_bypass` = 1, the request levels sampled at rising edge e are reflected on the outputs updated at that same edge e.
- R3: With `sync_bypass` = 0, a low request first sampled at edge e reaches the outputs at edge e+2, and is not yet visible after edge e+1.
- R4: Requests are level-sensitive. When a request wire returns high, `take_irq` falls with the same latency as in R2 or R3, and no released request is remembered.
- R5: A request whose enable (`fast_en` or `norm_en`) is 0 is ignored. When no line is both low and enabled, `take_irq` is 0 after the edge.
- R6: When both lines are low and enabled, the fast line wins: `take_irq` = 1, `sel_fast` = 1 and `vec_addr` = base + 0x1C.
- R7: When only the normal line is low and enabled, `take_irq` = 1, `sel_fast` = 0 and `vec_addr` = base + 0x18.
- R8: The vector base is 0x00000000 when `vec_high` = 0 and 0xFFFF0000 when `vec_high` = 1. The base is sampled at the same edge as the request.
- R9: On an edge where no request is taken, `sel_fast` and `vec_addr` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| fast_req_n | input | 1 | Fast interrupt request, active low, level |
| norm_req_n | input | 1 | Normal interrupt request, active low, level |
| fast_en | input | 1 | Core enable for the fast request, 1 = allowed |
| norm_en | input | 1 | Core enable for the normal request, 1 = allowed |
| sync_bypass | input | 1 | 1 = use the request wires directly, 0 = use the synchronized copies |
| vec_high | input | 1 | 1 = vector table at 0xFFFF0000, 0 = at 0x00000000 |
| take_irq | output | 1 | Registered: an enabled request is pending |
| sel_fast | output | 1 | Registered: 1 = fast line won, 0 = normal line won |
| vec_addr | output | 32 | Registered exception vector address of the winner |

## Verification
The synchronizer flops are the only hidden state. A flop that is stuck, or that resets low, shows on the ports as an early, late or spurious `take_irq` when the bypass is off. Such a fault is visible within three edges of the stimulus, or straight after reset. An error in the winner or vector register shows in the very next cycle, as the wrong `sel_fast`, a wrong low address byte or a wrong upper half. A register that fails to hold when idle shows as an address that changes while `take_irq` stays low.

// File: rtl/irq_fe_pkg.sv
// Package: shared constants for the interrupt request front end.
// Assumes two request lines; the index of each line is fixed here.
package irq_fe_pkg;
    localparam int NUM_LINES = 2;
    localparam int LINE_FAST = 0;
    localparam int LINE_NORM = 1;

    typedef enum logic {
        SRC_NORM = 1'b0,
        SRC_FAST = 1'b1
    } irq_src_e;
endpackage

// File: rtl/irq_sync.sv
// Module: irq_sync
// A chain of STAGES flops for each active-low request line. A pin chooses
// between the raw wire and the end of the chain. Every flop resets high
// (inactive), so reset never creates a request.
// Assumes STAGES >= 1 and that bypass is itself synchronous to clk.
module irq_sync #(
    parameter int LINES  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_n,
    input  logic             bypass,
    output logic [LINES-1:0] use_n
);
    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES-1:0] chain;

        // Shift the raw level along the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain <= '1;
            end else begin
                chain <= {chain[STAGES-2 >= 0 ? STAGES-2 : 0 : 0], raw_n[g]};
            end
        end

        // Choose the raw wire or the synchronized copy.
        always_comb begin
            use_n[g] = bypass ? raw_n[g] : chain[STAGES-1];
        end
    end
endmodule

// File: rtl/irq_arb.sv
// Module: irq_arb
// Qualifies each active-low request with its enable, then picks a winner
// with the fast line first. Purely combinational.
module irq_arb
    import irq_fe_pkg::*;
(
    input  logic [NUM_LINES-1:0] req_n,
    input  logic [NUM_LINES-1:0] en,
    output logic                 pend_any,
    output irq_src_e             winner
);
    logic [NUM_LINES-1:0] pend;

    // Pending means the wire is low and the core allows it.
    always_comb begin
        pend = ~req_n & en;
    end

    // The fast line has priority over the normal line.
    always_comb begin
        pend_any = |pend;
        winner   = pend[LINE_FAST] ? SRC_FAST : SRC_NORM;
    end
endmodule

// File: rtl/irq_vec_reg.sv
// Module: irq_vec_reg
// Registers the take strobe, the winner flag and the vector address. The
// base comes from the table-position pin. The flag and address hold their
// values on cycles with no request.
module irq_vec_reg
    import irq_fe_pkg::*;
#(
    parameter int                ADDR_W    = 32,
    parameter logic [ADDR_W-1:0] HIGH_BASE = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] FAST_OFF  = 32'h0000_001C,
    parameter logic [ADDR_W-1:0] NORM_OFF  = 32'h0000_0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pend_any,
    input  irq_src_e          winner,
    input  logic              vec_high,
    output logic              take,
    output logic              sel_fast,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] next_addr;

    // Form the winner's vector address from the base and its offset.
    always_comb begin
        base      = vec_high ? HIGH_BASE : '0;
        next_addr = base + ((winner == SRC_FAST) ? FAST_OFF : NORM_OFF);
    end

    // Register the outputs; the flag and address change only on a take.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take     <= 1'b0;
            sel_fast <= 1'b0;
            vec_addr <= '0;
        end else begin
            take <= pend_any;
            if (pend_any) begin
                sel_fast <= (winner == SRC_FAST);
                vec_addr <= next_addr;
            end
        end
    end
endmodule

// File: rtl/irq_front_end.sv
// Module: irq_front_end (top)
// Conditions the fast and normal active-low interrupt requests. Each one is
// optionally synchronized, then masked by its enable and arbitrated with the
// fast line first. The winner's vector address is registered.
// Assumes the enables, sync_bypass and vec_high are synchronous to clk.
module irq_front_end
    import irq_fe_pkg::*;
#(
    parameter int                ADDR_W      = 32,
    parameter int                SYNC_STAGES = 2,
    parameter logic [ADDR_W-1:0] HIGH_BASE   = 32'hFFFF_0000,
    parameter logic [ADDR_W-1:0] FAST_OFF    = 32'h0000_001C,
    parameter logic [ADDR_W-1:0] NORM_OFF    = 32'h0000_0018
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fast_req_n,
    input  logic              norm_req_n,
    input  logic              fast_en,
    input  logic              norm_en,
    input  logic              sync_bypass,
    input  logic              vec_high,
    output logic              take_irq,
    output logic              sel_fast,
    output logic [ADDR_W-1:0] vec_addr
);
    logic [NUM_LINES-1:0] raw_n;
    logic [NUM_LINES-1:0] use_n;
    logic [NUM_LINES-1:0] en_vec;
    logic                 pend_any;
    irq_src_e             winner;

    // Gather the request lines and enables into vectors by line index.
    always_comb begin
        raw_n            = '1;
        en_vec           = '0;
        raw_n[LINE_FAST] = fast_req_n;
        raw_n[LINE_NORM] = norm_req_n;
        en_vec[LINE_FAST] = fast_en;
        en_vec[LINE_NORM] = norm_en;
    end

    irq_sync #(
        .LINES (NUM_LINES),
        .STAGES(SYNC_STAGES)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_n (raw_n),
        .bypass(sync_bypass),
        .use_n (use_n)
    );

    irq_arb arb_i (
        .req_n   (use_n),
        .en      (en_vec),
        .pend_any(pend_any),
        .winner  (winner)
    );

    irq_vec_reg #(
        .ADDR_W   (ADDR_W),
        .HIGH_BASE(HIGH_BASE),
        .FAST_OFF (FAST_OFF),
        .NORM_OFF (NORM_OFF)
    ) vec_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .pend_any(pend_any),
        .winner  (winner),
        .vec_high(vec_high),
        .take    (take_irq),
        .sel_fast(sel_fast),
        .vec_addr(vec_addr)
    );
endmodule

// File: rtl/irq_front_end_chk.sv
// Module: irq_front_end_chk
// Port-level properties of the front end, attached to the top by bind.
module irq_front_end_chk #(
    parameter int                ADDR_W   = 32,
    parameter logic [ADDR_W-1:0] FAST_OFF = 32'h0000_001C,
    parameter logic [ADDR_W-1:0] NORM_OFF = 32'h0000_0018
) (
    input logic              clk,
    input logic              rst_n,
    input logic              fast_req_n,
    input logic              norm_req_n,
    input logic              fast_en,
    input logic              norm_en,
    input logic              sync_bypass,
    input logic              take_irq,
    input logic              sel_fast,
    input logic [ADDR_W-1:0] vec_addr
);
    // R6: in bypass mode an enabled low fast request wins at the next edge.
    p_fast_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bypass && !fast_req_n && fast_en) |=> (take_irq && sel_fast));

    // R7: in bypass mode an enabled normal request alone is selected.
    p_norm_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bypass && (fast_req_n || !fast_en) && !norm_req_n && norm_en)
        |=> (take_irq && !sel_fast));

    // R5: in bypass mode, with no enabled low request, nothing is taken.
    p_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_bypass && (fast_req_n || !fast_en) && (norm_req_n || !norm_en))
        |=> !take_irq);

    // R8: a taken request carries the offset of its winner.
    p_offset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_irq |-> (vec_addr[15:0] == (sel_fast ? FAST_OFF[15:0] : NORM_OFF[15:0])));

    // R9: without a take, the winner flag and the address do not move.
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !take_irq |-> ($stable(vec_addr) && $stable(sel_fast)));
endmodule

bind irq_front_end irq_front_end_chk #(
    .ADDR_W  (ADDR_W),
    .FAST_OFF(FAST_OFF),
    .NORM_OFF(NORM_OFF)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast_req_n (fast_req_n),
    .norm_req_n (norm_req_n),
    .fast_en    (fast_en),
    .norm_en    (norm_en),
    .sync_bypass(sync_bypass),
    .take_irq   (take_irq),
    .sel_fast   (sel_fast),
    .vec_addr   (vec_addr)
);

// File: tb/irq_front_end_tb_top.sv
// Directed bench for irq_front_end. Inputs change on falling edges and
// outputs are sampled on falling edges, each one after the rising edge
// that the check counts.
module irq_front_end_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fast_req_n = 1'b1;
    logic        norm_req_n = 1'b1;
    logic        fast_en = 1'b0;
    logic        norm_en = 1'b0;
    logic        sync_bypass = 1'b1;
    logic        vec_high = 1'b0;
    logic        take_irq;
    logic        sel_fast;
    logic [31:0] vec_addr;

    int tests = 0;
    int fails = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    irq_front_end dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fast_req_n (fast_req_n),
        .norm_req_n (norm_req_n),
        .fast_en    (fast_en),
        .norm_en    (norm_en),
        .sync_bypass(sync_bypass),
        .vec_high   (vec_high),
        .take_irq   (take_irq),
        .sel_fast   (sel_fast),
        .vec_addr   (vec_addr)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        tests++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive(input logic fr, input logic nr, input logic fe, input logic ne);
        fast_req_n = fr;
        norm_req_n = nr;
        fast_en    = fe;
        norm_en    = ne;
    endtask

    task automatic t_reset();
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        step(); step(); step();
        chk("R1 take in reset", {31'd0, take_irq}, 32'd0);
        chk("R1 sel in reset", {31'd0, sel_fast}, 32'd0);
        chk("R1 addr in reset", vec_addr, 32'd0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        rst_n = 1'b1;
        step();
        chk("R1 take after reset", {31'd0, take_irq}, 32'd0);
    endtask

    task automatic t_bypass_fast();
        sync_bypass = 1'b1; vec_high = 1'b0;
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        step();
        chk("R2 bypass take", {31'd0, take_irq}, 32'd1);
        chk("R2 bypass sel", {31'd0, sel_fast}, 32'd1);
        chk("R2 bypass addr", vec_addr, 32'h0000_001C);
    endtask

    task automatic t_norm_only();
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        step();
        chk("R7 norm take", {31'd0, take_irq}, 32'd1);
        chk("R7 norm sel", {31'd0, sel_fast}, 32'd0);
        chk("R7 norm addr", vec_addr, 32'h0000_0018);
    endtask

    task automatic t_both();
        drive(1'b0, 1'b0, 1'b1, 1'b1);
        step();
        chk("R6 both sel", {31'd0, sel_fast}, 32'd1);
        chk("R6 both addr", vec_addr, 32'h0000_001C);
    endtask

    task automatic t_mask();
        drive(1'b0, 1'b1, 1'b0, 1'b1);
        step();
        chk("R5 fast masked", {31'd0, take_irq}, 32'd0);
        drive(1'b0, 1'b0, 1'b0, 1'b1);
        step();
        chk("R5 masked fast lets norm win", {31'd0, sel_fast}, 32'd0);
        chk("R5 masked fast addr", vec_addr, 32'h0000_0018);
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        step();
        chk("R5 both masked", {31'd0, take_irq}, 32'd0);
    endtask

    task automatic t_release_bypass();
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        step();
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        step();
        chk("R4 release bypass", {31'd0, take_irq}, 32'd0);
        step();
        chk("R4 no latch", {31'd0, take_irq}, 32'd0);
    endtask

    task automatic t_high_and_hold();
        vec_high = 1'b1;
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        step();
        chk("R8 high fast addr", vec_addr, 32'hFFFF_001C);
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        step();
        chk("R8 high norm addr", vec_addr, 32'hFFFF_0018);
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        step();
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        vec_high = 1'b0;
        step();
        chk("R9 idle take", {31'd0, take_irq}, 32'd0);
        chk("R9 idle hold addr", vec_addr, 32'hFFFF_001C);
        chk("R9 idle hold sel", {31'd0, sel_fast}, 32'd1);
        drive(1'b1, 1'b0, 1'b1, 1'b1);
        step();
        chk("R8 low base back", vec_addr, 32'h0000_0018);
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        step();
    endtask

    task automatic t_sync_latency();
        sync_bypass = 1'b0;
        step(); step(); step();
        drive(1'b0, 1'b1, 1'b1, 1'b1);
        step();
        chk("R3 sync not after e", {31'd0, take_irq}, 32'd0);
        step();
        chk("R3 sync not after e+1", {31'd0, take_irq}, 32'd0);
        step();
        chk("R3 sync at e+2", {31'd0, take_irq}, 32'd1);
        chk("R3 sync sel", {31'd0, sel_fast}, 32'd1);
        drive(1'b1, 1'b1, 1'b1, 1'b1);
        step();
        chk("R4 sync release still up", {31'd0, take_irq}, 32'd1);
        step();
        chk("R4 sync release still up e+1", {31'd0, take_irq}, 32'd1);
        step();
        chk("R4 sync release drop", {31'd0, take_irq}, 32'd0);
        step();
        chk("R4 sync no latch", {31'd0, take_irq}, 32'd0);
        sync_bypass = 1'b1;
        step();
    endtask

    initial begin
        step();
        t_reset();
        t_bypass_fast();
        t_norm_only();
        t_both();
        t_mask();
        t_release_bypass();
        t_high_and_hold();
        t_sync_latency();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < 5000; i++) begin
            @(posedge clk);
        end
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule